// File: doc/BRIEF.md
# Host System Management Message Reflector

This block sits on the host side of a packet fabric and handles system management messages that arrive from upstream. Each message is a kind code plus an action code. Every message it accepts, whatever its kind, is sent again on all downstream links at once. Nothing is filtered. Each downstream link has its own valid/ready handshake, and a message stays pending until every link has taken it.

When the accepted message is a clock-stop assertion, the block does more than reflect it. After every link has taken the reflected copy, it broadcasts a grant message on all links. The grant carries the action code of the assertion, so each link sees the assertion before the grant. A status output reports that the host is in the stopped state. It is set when the grant broadcast has been taken by every link. It is cleared when a clock-stop deassertion message is accepted from upstream, and that deassertion is reflected like any other message.

Top module: `smr_reflector`

## Requirements
- R1: Out of reset, up_ready is 1, every bit of dn_valid is 0 and stop_granted is 0.
- R2: A message accepted upstream (up_valid and up_ready both 1 at a clock edge) appears on dn_valid for every link from the next cycle. Its dn_kind and dn_action equal the accepted values, for any kind code. The data stays unchanged while any link still has valid high.
- R3: Each link's dn_valid stays high until that link accepts (dn_ready high). It then drops in the following cycle and stays low for the rest of that broadcast, so no link receives a broadcast twice.
- R4: up_ready is 0 whenever any broadcast is pending. The block returns to accepting only in the cycle after the last link has taken the last broadcast that the message produced.
- R5: When the accepted kind is clock-stop assertion (kind 1), the cycle after the last link accepts the reflected copy presents a grant (kind 3) on all links. The grant carries the same action code.
- R6: stop_granted becomes 1 in the cycle after the last link accepts the grant. A grant that arrives from upstream as an ordinary message (kind 3) does not set it.
- R7: Accepting a clock-stop deassertion (kind 2) clears stop_granted in the next cycle. The deassertion is reflected on all links like any other message.
- R8: Messages of any other kind are only reflected. They leave stop_granted unchanged and produce no grant.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| up_valid | input | 1 | Upstream message present |
| up_ready | output | 1 | Block can accept an upstream message |
| up_kind | input | 4 | Upstream message kind code |
| up_action | input | ACT_W | Upstream action code |
| dn_valid | output | LINKS | Per-link message present |
| dn_ready | input | LINKS | Per-link acceptance |
| dn_kind | output | 4 | Kind code presented to all links |
| dn_action | output | ACT_W | Action code presented to all links |
| stop_granted | output | 1 | Host is in the stopped state |

## Verification
A stuck or lost per-link done flag shows at the ports in the very next cycle. The link's valid either rises again after that link has accepted, or never drops, which blocks up_ready for good. A wrong phase shows up at the boundary where the last link completes. A grant is missing or appears after a non-assertion message, or up_ready returns one cycle early or late, or stop_granted changes on the wrong edge. The bench compares every output against a queue model on every cycle. Any of these faults is therefore reported in the cycle it first appears. The runs use fully ready links, random back-pressure and one link held in a long stall.

// File: rtl/smr_pkg.sv
package smr_pkg;

    localparam int KIND_W = 4;

    typedef logic [KIND_W-1:0] kind_t;

    // Kind codes the block reacts to; every other code is only reflected.
    localparam kind_t KIND_STOP_ON  = 4'd1;
    localparam kind_t KIND_STOP_OFF = 4'd2;
    localparam kind_t KIND_GRANT    = 4'd3;

    typedef enum logic [1:0] {
        PH_IDLE    = 2'd0,
        PH_REFLECT = 2'd1,
        PH_GRANT   = 2'd2
    } phase_e;

endpackage

// File: rtl/smr_link_tracker.sv
// Per-link completion flags for one broadcast. A link's valid is held
// until that link accepts; 'arm' starts a fresh broadcast.
module smr_link_tracker #(
    parameter int LINKS = 3
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             arm,
    input  logic             active,
    input  logic [LINKS-1:0] dn_ready,
    output logic [LINKS-1:0] dn_valid,
    output logic             all_done
);

    typedef struct packed {
        logic [LINKS-1:0] done;
    } trk_t;

    trk_t             st_d, st_q;
    logic [LINKS-1:0] taken;
    logic [LINKS-1:0] done_now;

    for (genvar g = 0; g < LINKS; g++) begin : g_link
        assign dn_valid[g] = active & ~st_q.done[g];
        assign taken[g]    = dn_valid[g] & dn_ready[g];
        assign done_now[g] = st_q.done[g] | taken[g];
    end

    assign all_done = active & (&done_now);

    always_comb begin
        st_d = st_q;
        if (arm) begin
            st_d.done = '0;
        end else begin
            st_d.done = done_now;
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

endmodule

// File: rtl/smr_seq_ctrl.sv
// Phase control: capture, reflect, optional grant, stop-state tracking.
module smr_seq_ctrl
    import smr_pkg::*;
#(
    parameter int ACT_W = 8
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             up_valid,
    input  kind_t            up_kind,
    input  logic [ACT_W-1:0] up_action,
    input  logic             all_done,
    output logic             up_ready,
    output logic             arm,
    output logic             active,
    output kind_t            out_kind,
    output logic [ACT_W-1:0] out_action,
    output logic             stop_granted
);

    typedef struct packed {
        phase_e           phase;
        kind_t            kind;
        logic [ACT_W-1:0] action;
        logic             stop;
    } ctl_t;

    ctl_t st_d, st_q;

    assign up_ready     = (st_q.phase == PH_IDLE);
    assign active       = (st_q.phase != PH_IDLE);
    assign out_kind     = (st_q.phase == PH_GRANT) ? KIND_GRANT : st_q.kind;
    assign out_action   = st_q.action;
    assign stop_granted = st_q.stop;

    always_comb begin
        st_d = st_q;
        arm  = 1'b0;
        unique case (st_q.phase)
            PH_IDLE: begin
                if (up_valid) begin
                    st_d.kind   = up_kind;
                    st_d.action = up_action;
                    st_d.phase  = PH_REFLECT;
                    arm         = 1'b1;
                    if (up_kind == KIND_STOP_OFF) begin
                        st_d.stop = 1'b0;
                    end
                end
            end
            PH_REFLECT: begin
                if (all_done) begin
                    if (st_q.kind == KIND_STOP_ON) begin
                        st_d.phase = PH_GRANT;
                        arm        = 1'b1;
                    end else begin
                        st_d.phase = PH_IDLE;
                    end
                end
            end
            PH_GRANT: begin
                if (all_done) begin
                    st_d.phase = PH_IDLE;
                    st_d.stop  = 1'b1;
                end
            end
            default: begin
                st_d.phase = PH_IDLE;
            end
        endcase
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            st_q <= '{phase: PH_IDLE, kind: '0, action: '0, stop: 1'b0};
        end else begin
            st_q <= st_d;
        end
    end

endmodule

// File: rtl/smr_reflector.sv
module smr_reflector
    import smr_pkg::*;
#(
    parameter int LINKS = 3,
    parameter int ACT_W = 8
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             up_valid,
    output logic             up_ready,
    input  logic [3:0]       up_kind,
    input  logic [ACT_W-1:0] up_action,
    output logic [LINKS-1:0] dn_valid,
    input  logic [LINKS-1:0] dn_ready,
    output logic [3:0]       dn_kind,
    output logic [ACT_W-1:0] dn_action,
    output logic             stop_granted
);

    logic  arm;
    logic  active;
    logic  all_done;
    kind_t kind_w;

    smr_seq_ctrl #(
        .ACT_W(ACT_W)
    ) i_ctrl (
        .clk         (clk),
        .rst_n       (rst_n),
        .up_valid    (up_valid),
        .up_kind     (up_kind),
        .up_action   (up_action),
        .all_done    (all_done),
        .up_ready    (up_ready),
        .arm         (arm),
        .active      (active),
        .out_kind    (kind_w),
        .out_action  (dn_action),
        .stop_granted(stop_granted)
    );

    smr_link_tracker #(
        .LINKS(LINKS)
    ) i_links (
        .clk     (clk),
        .rst_n   (rst_n),
        .arm     (arm),
        .active  (active),
        .dn_ready(dn_ready),
        .dn_valid(dn_valid),
        .all_done(all_done)
    );

    assign dn_kind = kind_w;

endmodule

// File: rtl/smr_reflector_chk.sv
module smr_reflector_chk #(
    parameter int LINKS = 3,
    parameter int ACT_W = 8
) (
    input logic             clk,
    input logic             rst_n,
    input logic             up_valid,
    input logic             up_ready,
    input logic [3:0]       up_kind,
    input logic [LINKS-1:0] dn_valid,
    input logic [LINKS-1:0] dn_ready,
    input logic [3:0]       dn_kind,
    input logic [ACT_W-1:0] dn_action,
    input logic             stop_granted
);

    p_reset_state_r1: assert property (@(posedge clk)
        $rose(rst_n) |-> (up_ready && dn_valid == '0 && !stop_granted));

    p_data_stable_r2: assert property (@(posedge clk) disable iff (!rst_n)
        (|(dn_valid & ~dn_ready)) |=> ($stable(dn_kind) && $stable(dn_action)));

    for (genvar g = 0; g < LINKS; g++) begin : g_hold
        p_valid_hold_r3: assert property (@(posedge clk) disable iff (!rst_n)
            (dn_valid[g] && !dn_ready[g]) |=> dn_valid[g]);
    end

    p_stall_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (|dn_valid) |-> !up_ready);

    p_grant_follows_r5: assert property (@(posedge clk) disable iff (!rst_n)
        ((|dn_valid) && dn_kind == 4'd3 && $past(!up_ready))
        |-> ((($past(dn_kind) == 4'd1) || ($past(dn_kind) == 4'd3))
             && $stable(dn_action)));

    p_stop_set_r6: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(stop_granted) |-> ($past(dn_kind) == 4'd3 && up_ready));

    p_stop_clear_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (up_valid && up_ready && up_kind == 4'd2) |=> !stop_granted);

endmodule

bind smr_reflector smr_reflector_chk #(
    .LINKS(LINKS),
    .ACT_W(ACT_W)
) i_smr_chk (
    .clk         (clk),
    .rst_n       (rst_n),
    .up_valid    (up_valid),
    .up_ready    (up_ready),
    .up_kind     (up_kind),
    .dn_valid    (dn_valid),
    .dn_ready    (dn_ready),
    .dn_kind     (dn_kind),
    .dn_action   (dn_action),
    .stop_granted(stop_granted)
);

// File: tb/test_smr_reflector.sv
module test_smr_reflector;

    localparam int CLK_PERIOD = 10;
    localparam int LINKS      = 3;
    localparam int ACT_W      = 8;

    logic             clk = 1'b0;
    logic             rst_n = 1'b0;
    logic             up_valid = 1'b0;
    logic             up_ready;
    logic [3:0]       up_kind = '0;
    logic [ACT_W-1:0] up_action = '0;
    logic [LINKS-1:0] dn_valid;
    logic [LINKS-1:0] dn_ready = '0;
    logic [3:0]       dn_kind;
    logic [ACT_W-1:0] dn_action;
    logic             stop_granted;

    always #(CLK_PERIOD/2) clk = ~clk;

    smr_reflector #(.LINKS(LINKS), .ACT_W(ACT_W)) i_smr_reflector (
        .clk(clk), .rst_n(rst_n), .up_valid(up_valid), .up_ready(up_ready),
        .up_kind(up_kind), .up_action(up_action), .dn_valid(dn_valid),
        .dn_ready(dn_ready), .dn_kind(dn_kind), .dn_action(dn_action),
        .stop_granted(stop_granted)
    );

    typedef struct {
        int kind;
        int action;
        bit grant;
    } item_t;

    item_t          q[$];
    bit [LINKS-1:0] m_done;
    bit             m_stop;
    int             n_cmp = 0;
    int             n_bad = 0;
    int             n_grants = 0;
    int             n_stops = 0;
    bit             finished = 0;

    task automatic check(string tag, int act, int exp);
        n_cmp++;
        if (act != exp) begin
            n_bad++;
            $display("FAIL %s actual=%0d expected=%0d at %0t", tag, act, exp, $time);
        end
    endtask

    function automatic bit m_ready();
        return q.size() == 0;
    endfunction

    function automatic bit m_valid(int i);
        return (q.size() != 0) && !m_done[i];
    endfunction

    // Advance the model across one clock edge using the inputs held there.
    task automatic model_step();
        bit [LINKS-1:0] hs;
        item_t it;
        for (int i = 0; i < LINKS; i++) hs[i] = m_valid(i) && dn_ready[i];
        if (q.size() != 0) begin
            m_done = m_done | hs;
            if (&m_done) begin
                it = q.pop_front();
                m_done = '0;
                if (it.grant) m_stop = 1;
            end
        end else if (up_valid) begin
            it = '{kind: int'(up_kind), action: int'(up_action), grant: 0};
            q.push_back(it);
            if (up_kind == 4'd2) m_stop = 0;
            if (up_kind == 4'd1) begin
                it.kind = 3;
                it.grant = 1;
                q.push_back(it);
            end
        end
    endtask

    task automatic compare_all();
        bit any;
        any = 0;
        check("R4 up_ready", int'(up_ready), int'(m_ready()));
        for (int i = 0; i < LINKS; i++) begin
            check("R3 dn_valid", int'(dn_valid[i]), int'(m_valid(i)));
            any |= m_valid(i);
        end
        if (any) begin
            if (q[0].grant) begin
                check("R5 grant kind", int'(dn_kind), 3);
                check("R5 grant action", int'(dn_action), q[0].action);
            end else begin
                check("R2 kind", int'(dn_kind), q[0].kind);
                check("R2 action", int'(dn_action), q[0].action);
            end
        end
        check("R6/R7/R8 stop_granted", int'(stop_granted), int'(m_stop));
        if (stop_granted && m_stop) n_stops++;
    endtask

    task automatic run_phase(int cycles, int up_pct, int rdy_pct, int stall_link, int stall_pct);
        int pick;
        for (int c = 0; c < cycles; c++) begin
            up_valid = ($urandom_range(99) < up_pct);
            pick = $urandom_range(7);
            case (pick)
                0, 1:    up_kind = 4'd1;
                2, 3:    up_kind = 4'd2;
                4:       up_kind = 4'd3;
                5:       up_kind = 4'd0;
                6:       up_kind = 4'd7;
                default: up_kind = 4'd15;
            endcase
            up_action = ACT_W'($urandom);
            for (int i = 0; i < LINKS; i++) begin
                if (i == stall_link)
                    dn_ready[i] = ($urandom_range(99) >= stall_pct);
                else
                    dn_ready[i] = ($urandom_range(99) < rdy_pct);
            end
            @(posedge clk);
            @(negedge clk);
            if (q.size() != 0 && q[0].grant && m_done == '0) n_grants++;
            model_step();
            compare_all();
        end
    endtask

    initial begin
        #(CLK_PERIOD * 200000);
        if (!finished) begin
            n_bad++;
            $display("FAIL watchdog expired");
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
            $finish;
        end
    end

    initial begin
        m_done = '0;
        m_stop = 0;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        // R1: reset values before the first active edge
        check("R1 up_ready", int'(up_ready), 1);
        check("R1 dn_valid", int'(dn_valid), 0);
        check("R1 stop_granted", int'(stop_granted), 0);
        run_phase(400, 60, 100, -1, 0);   // R2 R5: all links always ready
        run_phase(1500, 50, 50, -1, 0);   // R3 R4: random back-pressure
        run_phase(1500, 70, 90, 1, 92);   // R3 R4: one link held in long stalls
        run_phase(600, 30, 70, 2, 40);    // R6 R7 R8: mixed kinds
        check("R5 grants seen", int'(n_grants > 0), 1);
        check("R6 stop state reached", int'(n_stops > 0), 1);
        finished = 1;
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    end

endmodule